// File: doc/BRIEF.md
# Sleep Mode Time Base Switcher

This block sits beside a windowed watchdog inside a supply supervisor. It watches the strobes the watchdog raises each time it issues a timeout reset pulse. When the supervised processor lets several such periods go by in a row without touching its service line, the processor is taken to be idle. The block then moves the supervisor onto a slow, low-power time base. In that base it produces its own brief reset pulse once per slow period, so that a sleeping processor is still prodded now and then.

Sleep ends the moment the service line moves in either direction, or when the supply-good flag drops. After a supply drop, the block comes back up in the normal base and needs a fresh run of missed periods before it can sleep again. The service line is asynchronous and passes through a synchroniser before any edge is taken from it. The tick that the rest of the supervisor should count is passed out on `base_tick`, chosen from the two tick enables according to the current mode.

The controller has four states. OFF means the supply is not good. AWAKE is the normal time base, in which missed periods are counted. DOZE is the slow base with no pulse active, and KICK is the slow base with the sleep reset pulse active. The transitions are as follows. POWER_UP goes from OFF to AWAKE when the supply is good. FALL_ASLEEP goes from AWAKE to DOZE when the count of missed periods is reached. KICK_START goes from DOZE to KICK when the pulse window of the slow period begins. KICK_END goes from KICK to DOZE when the slow period wraps. WAKE goes from DOZE or KICK to AWAKE on a service edge. BROWN_OUT goes from any state to OFF while the supply is not good.

Top module: `sleep_base_switch`

## Requirements
- R1: Out of reset, `slow_sel`, `sleep_flag` and `sleep_rst` are all 0, and `base_tick` follows `norm_tick`.
- R2: `sleep_flag` and `slow_sel` become 1 on the clock edge that samples the third consecutive `to_strobe` high, with no service edge since the count last cleared. After only two such strobes they stay 0. The count is set by parameter MISS_LIMIT, which defaults to 3.
- R3: A service edge of either polarity while awake clears the count of missed periods, so three further strobes are needed after it.
- R4: While asleep, `base_tick` equals `slow_tick`. While awake, it equals `norm_tick`.
- R5: In sleep, `sleep_rst` is high for PULSE_TICKS slow ticks at the end of each period of PERIOD_TICKS slow ticks, and low for the rest of the period. The first pulse starts after PERIOD_TICKS-PULSE_TICKS ticks counted from entry. The defaults are 320 and 1, and PULSE_TICKS must be less than PERIOD_TICKS.
- R6: A rising edge on `svc_in` ends sleep. `sleep_flag` reads 0 on the third clock edge after the change: two synchroniser stages, then the state register.
- R7: A falling edge on `svc_in` ends sleep with the same latency as R6.
- R8: While `supply_ok` is 0, the block is in the normal base with `sleep_flag` at 0 one edge later. It ignores `to_strobe` and discards any partial miss count.
- R9: The sleep period advances only on cycles with `slow_tick` high. With the tick every second cycle, the pulses are 2*PERIOD_TICKS cycles apart and 2*PULSE_TICKS cycles wide.
- R10: `to_strobe` has no effect while asleep: the block stays asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| norm_tick | input | 1 | Normal time base tick enable |
| slow_tick | input | 1 | Slow time base tick enable |
| svc_in | input | 1 | Asynchronous watchdog service line from the processor |
| supply_ok | input | 1 | Supply-good flag, 1 when the supply is good |
| to_strobe | input | 1 | One-cycle strobe per watchdog timeout reset pulse |
| base_tick | output | 1 | Tick of the selected time base |
| slow_sel | output | 1 | 1 when the slow time base is selected |
| sleep_flag | output | 1 | 1 while in sleep mode |
| sleep_rst | output | 1 | Periodic reset pulse generated in sleep mode |

## Verification
The bench checks that the block falls asleep exactly on the third missed period and not on the second. An off-by-one counter would sleep a period early or a period late. It then puts a service edge between strobes; a design that forgot to clear the count would sleep too soon. Both edge polarities are tested for the wake-up, because a detector that sees only one polarity would leave a processor that parks its line high or low stuck in sleep. The pulse spacing is measured with the slow tick both continuous and at half rate, and strobes are sent during sleep and during a supply drop. These cases catch a phase counter that runs on the system clock, a sleep that a stray strobe can end, and a miss count that survives a brown-out.

// File: rtl/sleep_switch_pkg.sv
package sleep_switch_pkg;

    // Controller states of the sleep mode switcher
    typedef enum logic [1:0] {
        SM_OFF    = 2'd0,   // supply not good
        SM_AWAKE  = 2'd1,   // normal base, counting missed periods
        SM_DOZE   = 2'd2,   // slow base, pulse inactive
        SM_KICK   = 2'd3    // slow base, sleep reset pulse active
    } sm_state_t;

endpackage

// File: rtl/sm_edge_sync.sv
module sm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic any_edge
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Either polarity of change in the synchronised level
    assign any_edge = sync_q[SYNC_STAGES-1] ^ prev_q;

endmodule

// File: rtl/sm_miss_count.sv
module sm_miss_count #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic limit_hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (clr)                cnt_q <= '0;
        else if (inc && cnt_q == LAST) cnt_q <= '0;
        else if (inc)                cnt_q <= cnt_q + 1'b1;
    end

    // Clear wins over a coincident strobe
    assign limit_hit = inc && !clr && (cnt_q == LAST);

endmodule

// File: rtl/sm_slow_phase.sv
module sm_slow_phase #(
    parameter int PERIOD = 320,
    parameter int PULSE  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic pulse_begin,
    output logic period_wrap
);
    localparam int PW = $clog2(PERIOD);
    localparam logic [PW-1:0] LAST_PH  = PW'(PERIOD - 1);
    localparam logic [PW-1:0] PRE_PH   = PW'(PERIOD - PULSE - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   phase_q <= '0;
        else if (!run)                phase_q <= '0;
        else if (tick && phase_q == LAST_PH) phase_q <= '0;
        else if (tick)                phase_q <= phase_q + 1'b1;
    end

    assign pulse_begin = run && tick && (phase_q == PRE_PH);
    assign period_wrap = run && tick && (phase_q == LAST_PH);

endmodule

// File: rtl/sleep_base_switch.sv
module sleep_base_switch
    import sleep_switch_pkg::*;
#(
    parameter int MISS_LIMIT   = 3,
    parameter int PERIOD_TICKS = 320,
    parameter int PULSE_TICKS  = 1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic norm_tick,
    input  logic slow_tick,
    input  logic svc_in,
    input  logic supply_ok,
    input  logic to_strobe,
    output logic base_tick,
    output logic slow_sel,
    output logic sleep_flag,
    output logic sleep_rst
);
    sm_state_t state_q, state_d;
    logic      svc_edge;
    logic      miss_clr, miss_inc, miss_hit;
    logic      asleep, pulse_begin, period_wrap;

    sm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(svc_in), .any_edge(svc_edge)
    );

    assign asleep   = (state_q == SM_DOZE) || (state_q == SM_KICK);
    assign miss_clr = svc_edge || !supply_ok || (state_q != SM_AWAKE);
    assign miss_inc = to_strobe && supply_ok && (state_q == SM_AWAKE);

    sm_miss_count #(.LIMIT(MISS_LIMIT)) u_miss (
        .clk(clk), .rst_n(rst_n), .clr(miss_clr), .inc(miss_inc),
        .limit_hit(miss_hit)
    );

    sm_slow_phase #(.PERIOD(PERIOD_TICKS), .PULSE(PULSE_TICKS)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(asleep), .tick(slow_tick),
        .pulse_begin(pulse_begin), .period_wrap(period_wrap)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SM_OFF:   if (supply_ok) state_d = SM_AWAKE;         // POWER_UP
            SM_AWAKE: if (miss_hit)  state_d = SM_DOZE;          // FALL_ASLEEP
            SM_DOZE: begin
                if (svc_edge)         state_d = SM_AWAKE;        // WAKE
                else if (pulse_begin) state_d = SM_KICK;         // KICK_START
            end
            SM_KICK: begin
                if (svc_edge)         state_d = SM_AWAKE;        // WAKE
                else if (period_wrap) state_d = SM_DOZE;         // KICK_END
            end
            default:                  state_d = SM_OFF;
        endcase
        if (!supply_ok) state_d = SM_OFF;                        // BROWN_OUT
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SM_OFF;
        else        state_q <= state_d;
    end

    // Outputs from state
    always_comb begin
        slow_sel   = 1'b0;
        sleep_flag = 1'b0;
        sleep_rst  = 1'b0;
        unique case (state_q)
            SM_OFF, SM_AWAKE: ;
            SM_DOZE: begin
                slow_sel   = 1'b1;
                sleep_flag = 1'b1;
            end
            SM_KICK: begin
                slow_sel   = 1'b1;
                sleep_flag = 1'b1;
                sleep_rst  = 1'b1;
            end
            default: ;
        endcase
        base_tick = slow_sel ? slow_tick : norm_tick;
    end

endmodule

// File: rtl/sm_sleep_chk.sv
module sm_sleep_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic to_strobe,
    input logic svc_edge,
    input logic sleep_flag,
    input logic sleep_rst
);
    AST_PULSE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_rst |-> sleep_flag);                                      // R5
    AST_BROWNOUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !sleep_flag);                                    // R8
    AST_EDGE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        svc_edge |=> !sleep_flag);                                      // R6
    AST_ENTRY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_flag) |-> $past(to_strobe));                        // R2
    AST_STROBE_IN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_flag && to_strobe && supply_ok && !svc_edge) |=> sleep_flag); // R10
endmodule

bind sleep_base_switch sm_sleep_chk u_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .to_strobe(to_strobe),
    .svc_edge(svc_edge), .sleep_flag(sleep_flag), .sleep_rst(sleep_rst)
);

// File: tb/sim_sleep_base_switch.sv
module sim_sleep_base_switch;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic norm_tick = 1'b0, slow_tick = 1'b0, svc_in = 1'b0;
    logic supply_ok = 1'b1, to_strobe = 1'b0;
    logic base_tick, slow_sel, sleep_flag, sleep_rst;
    int   n_checks = 0, n_fail = 0;
    bit   done = 1'b0;
    bit   half_rate = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sleep_base_switch u0 (
        .clk(clk), .rst_n(rst_n), .norm_tick(norm_tick), .slow_tick(slow_tick),
        .svc_in(svc_in), .supply_ok(supply_ok), .to_strobe(to_strobe),
        .base_tick(base_tick), .slow_sel(slow_sel), .sleep_flag(sleep_flag),
        .sleep_rst(sleep_rst)
    );

    // Half-rate slow tick generator
    always @(negedge clk) if (half_rate) slow_tick <= ~slow_tick;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) to_strobe = 1'b1;
        @(negedge clk) to_strobe = 1'b0;
    endtask

    task automatic toggle_svc();
        @(negedge clk) svc_in = ~svc_in;
        repeat (3) @(negedge clk);
    endtask

    task automatic go_sleep();
        repeat (3) strobe();
    endtask

    task automatic wait_rst(input logic lvl, output int n);
        n = 0;
        while (sleep_rst !== lvl && n < 5000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(sleep_flag == 0 && slow_sel == 0 && sleep_rst == 0, "R1 outputs", sleep_flag, 0);
        norm_tick = 1'b1; #1;
        check(base_tick == 1, "R1 base_tick", base_tick, 1);
        norm_tick = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_entry();
        strobe(); strobe();
        repeat (5) @(negedge clk);
        check(sleep_flag == 0, "R2 no sleep after two", sleep_flag, 0);
        strobe();
        check(sleep_flag == 1 && slow_sel == 1, "R2 sleep after third", sleep_flag, 1);
    endtask

    task automatic t_rise_exit();
        @(negedge clk) svc_in = 1'b1;
        repeat (2) @(negedge clk);
        check(sleep_flag == 1, "R6 still asleep mid-sync", sleep_flag, 1);
        @(negedge clk);
        check(sleep_flag == 0 && slow_sel == 0, "R6 rising edge exit", sleep_flag, 0);
    endtask

    task automatic t_fall_exit();
        go_sleep();
        check(sleep_flag == 1, "R7 asleep", sleep_flag, 1);
        @(negedge clk) svc_in = 1'b0;
        repeat (3) @(negedge clk);
        check(sleep_flag == 0, "R7 falling edge exit", sleep_flag, 0);
    endtask

    task automatic t_count_clear();
        strobe(); strobe();
        toggle_svc();
        strobe(); strobe();
        repeat (3) @(negedge clk);
        check(sleep_flag == 0, "R3 count cleared by edge", sleep_flag, 0);
        strobe();
        check(sleep_flag == 1, "R3 sleep after three fresh", sleep_flag, 1);
        toggle_svc();
    endtask

    task automatic t_mux();
        go_sleep();
        norm_tick = 1'b0; slow_tick = 1'b1; #1;
        check(base_tick == 1, "R4 slow tick in sleep", base_tick, 1);
        norm_tick = 1'b1; slow_tick = 1'b0; #1;
        check(base_tick == 0, "R4 norm tick ignored in sleep", base_tick, 0);
        toggle_svc();
        #1;
        check(base_tick == 1, "R4 norm tick when awake", base_tick, 1);
        norm_tick = 1'b0;
    endtask

    task automatic t_pulses();
        int n1, w, n2;
        slow_tick = 1'b1;
        go_sleep();
        wait_rst(1'b1, n1);
        check(n1 == 319, "R5 first pulse offset", n1, 319);
        wait_rst(1'b0, w);
        check(w == 1, "R5 pulse width", w, 1);
        wait_rst(1'b1, n2);
        check(n2 + w == 320, "R5 pulse spacing", n2 + w, 320);
        repeat (3) strobe();
        check(sleep_flag == 1, "R10 strobes ignored in sleep", sleep_flag, 1);
        toggle_svc();
        slow_tick = 1'b0;
    endtask

    task automatic t_half_rate();
        int a, w, b;
        go_sleep();
        half_rate = 1'b1;
        wait_rst(1'b1, a);
        wait_rst(1'b0, w);
        check(w == 2, "R9 width at half rate", w, 2);
        wait_rst(1'b1, b);
        check(w + b == 640, "R9 spacing at half rate", w + b, 640);
        half_rate = 1'b0;
        @(negedge clk) slow_tick = 1'b0;
        toggle_svc();
        check(sleep_flag == 0, "R9 exit", sleep_flag, 0);
    endtask

    task automatic t_supply();
        go_sleep();
        @(negedge clk) supply_ok = 1'b0;
        @(negedge clk);
        check(sleep_flag == 0 && slow_sel == 0, "R8 brown-out exit", sleep_flag, 0);
        supply_ok = 1'b1;
        repeat (2) @(negedge clk);
        strobe(); strobe();
        @(negedge clk) supply_ok = 1'b0;
        strobe(); strobe();
        @(negedge clk) supply_ok = 1'b1;
        repeat (2) @(negedge clk);
        strobe(); strobe();
        check(sleep_flag == 0, "R8 count discarded and strobes ignored", sleep_flag, 0);
        strobe();
        check(sleep_flag == 1, "R8 sleep after three fresh", sleep_flag, 1);
    endtask

    initial begin
        t_reset();
        t_entry();
        t_rise_exit();
        t_fall_exit();
        t_count_clear();
        t_mux();
        t_pulses();
        t_half_rate();
        t_supply();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule